// File: doc/BRIEF.md
# I2C Target Address Selector

This block sits in the front end of an I2C target and settles two things: which 7-bit address the device answers to, and whether an incoming address byte is meant for it. The device address normally comes from three board strap pins that pick one of eight devices on a shared bus. The upper four address bits are a fixed prefix. If every strap reads low, which is also how unconnected pins read because they are pulled low, the block uses an address loaded from nonvolatile storage instead of the pin-derived one.

The straps pass through a synchronizer and are frozen when reset is released, so board noise or a late strap change cannot move the address while the device is running. A serial shift register upstream delivers the first byte after START with a one-cycle valid strobe. The block compares that byte against the effective address and registers a hit flag for the acknowledge logic, together with the transfer direction. START/STOP detection, the data phase and the storage itself belong to other blocks.

Top module: `i2c_addr_select`

## Requirements
- R1: When the latched strap value is nonzero, `eff_addr` equals the prefix parameter in bits [6:3] followed by the straps, with strap[0] in bit 0. It is updated one clock after the latched value.
- R2: When the latched strap value is all zero, `eff_addr` follows `nv_addr`, one clock behind it.
- R3: The straps pass through a two-stage synchronizer and are captured on every clock while `rst` is high. After reset is released, strap changes have no effect on `eff_addr` until the next reset.
- R4: On the clock after `addr_vld` is high, `addr_hit` is 1 exactly when `addr_byte[7:1]` (address bits, MSB first, in bit 7) equals `eff_addr`.
- R5: Between strobes, `addr_hit` and `rw_dir` hold their value whatever `addr_byte` does. They change only at a strobe.
- R6: On the clock after a strobe, `rw_dir` equals `addr_byte[0]`, where 1 means read and 0 means write.
- R7: While `rst` is high, `eff_addr`, `addr_hit` and `rw_dir` are all 0 on the clock after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; straps latch while high |
| strap | input | 3 | Device-select strap pins, asynchronous, open reads 0 |
| nv_addr | input | 7 | Address loaded from nonvolatile storage |
| addr_byte | input | 8 | Received address byte: [7:1] address, [0] direction |
| addr_vld | input | 1 | One-cycle strobe marking `addr_byte` valid |
| eff_addr | output | 7 | Effective device address in use |
| addr_hit | output | 1 | Registered match of the last strobed byte |
| rw_dir | output | 1 | Registered direction bit of the last strobed byte |

## Verification
The bench builds the block with the default 7-bit address and 3-bit strap widths, and overrides the prefix to 4'b1101 instead of the default. A prefix-insertion fault therefore shows up as a wrong address even with straps that would hide it under the default prefix. Each table vector resets the block with a new strap setting, so the pin-derived and stored-address paths are both exercised across several strap codes. Directed tests then move the straps after reset, move the stored address while the fallback is active, and change the byte between strobes.

// File: rtl/addr_sel_pkg.sv
package addr_sel_pkg;
  localparam int DEF_ADDR_W = 7;
  localparam int DEF_DEV_W  = 3;
  localparam int DEF_SYNC   = 2;

  typedef struct packed {
    logic hit;
    logic rd;
  } match_t;
endpackage

// File: rtl/strap_latch.sv
module strap_latch #(
  parameter int DEV_W = addr_sel_pkg::DEF_DEV_W,
  parameter int SYNC  = addr_sel_pkg::DEF_SYNC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DEV_W-1:0] strap,
  output logic [DEV_W-1:0] strap_lat
);
  logic [DEV_W-1:0] chain [SYNC];

  // Synchronizer runs freely so that it has settled by reset release.
  always_ff @(posedge clk) begin
    chain[0] <= strap;
    for (int i = 1; i < SYNC; i++) chain[i] <= chain[i-1];
  end

  // Captured throughout reset, frozen afterwards.
  always_ff @(posedge clk) begin
    if (rst) strap_lat <= chain[SYNC-1];
  end

  assert_frozen_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(strap_lat));
endmodule

// File: rtl/addr_resolve.sv
module addr_resolve #(
  parameter int ADDR_W = addr_sel_pkg::DEF_ADDR_W,
  parameter int DEV_W  = addr_sel_pkg::DEF_DEV_W,
  parameter logic [ADDR_W-DEV_W-1:0] PREFIX = 4'b1010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DEV_W-1:0]  strap_lat,
  input  logic [ADDR_W-1:0] nv_addr,
  output logic [ADDR_W-1:0] eff_addr
);
  logic use_nv;
  assign use_nv = (strap_lat == '0);

  always_ff @(posedge clk) begin
    if (rst)         eff_addr <= '0;
    else if (use_nv) eff_addr <= nv_addr;
    else             eff_addr <= {PREFIX, strap_lat};
  end

  assert_fallback_R2: assert property (@(posedge clk) disable iff (rst)
    (strap_lat == '0) |=> eff_addr == $past(nv_addr));
  assert_pin_addr_R1: assert property (@(posedge clk) disable iff (rst)
    (strap_lat != '0) |=> eff_addr[DEV_W-1:0] == $past(strap_lat));
  assert_prefix_R1: assert property (@(posedge clk) disable iff (rst)
    (strap_lat != '0) |=> eff_addr[ADDR_W-1:DEV_W] == PREFIX);
endmodule

// File: rtl/addr_compare.sv
module addr_compare #(
  parameter int ADDR_W = addr_sel_pkg::DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W:0]   addr_byte,
  input  logic              addr_vld,
  input  logic [ADDR_W-1:0] eff_addr,
  output addr_sel_pkg::match_t result
);
  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
    end else if (addr_vld) begin
      result.hit <= (addr_byte[ADDR_W:1] == eff_addr);
      result.rd  <= addr_byte[0];
    end
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !addr_vld |=> $stable(result));
  assert_dir_R6: assert property (@(posedge clk) disable iff (rst)
    addr_vld |=> result.rd == $past(addr_byte[0]));
  assert_miss_R4: assert property (@(posedge clk) disable iff (rst)
    (addr_vld && addr_byte[ADDR_W:1] != eff_addr) |=> !result.hit);
endmodule

// File: rtl/i2c_addr_select.sv
module i2c_addr_select #(
  parameter int ADDR_W = addr_sel_pkg::DEF_ADDR_W,
  parameter int DEV_W  = addr_sel_pkg::DEF_DEV_W,
  parameter int SYNC   = addr_sel_pkg::DEF_SYNC,
  parameter logic [ADDR_W-DEV_W-1:0] PREFIX = 4'b1010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DEV_W-1:0]  strap,
  input  logic [ADDR_W-1:0] nv_addr,
  input  logic [ADDR_W:0]   addr_byte,
  input  logic              addr_vld,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              addr_hit,
  output logic              rw_dir
);
  logic [DEV_W-1:0] strap_lat;
  addr_sel_pkg::match_t res;

  strap_latch #(.DEV_W(DEV_W), .SYNC(SYNC)) u_latch (
    .clk(clk), .rst(rst), .strap(strap), .strap_lat(strap_lat));

  addr_resolve #(.ADDR_W(ADDR_W), .DEV_W(DEV_W), .PREFIX(PREFIX)) u_resolve (
    .clk(clk), .rst(rst), .strap_lat(strap_lat), .nv_addr(nv_addr),
    .eff_addr(eff_addr));

  addr_compare #(.ADDR_W(ADDR_W)) u_cmp (
    .clk(clk), .rst(rst), .addr_byte(addr_byte), .addr_vld(addr_vld),
    .eff_addr(eff_addr), .result(res));

  assign addr_hit = res.hit;
  assign rw_dir   = res.rd;

  assert_reset_R7: assert property (@(posedge clk)
    rst |=> (eff_addr == '0 && !addr_hit && !rw_dir));
endmodule

// File: tb/i2c_addr_select_test.sv
module i2c_addr_select_test;
  logic clk = 0, rst = 1;
  logic [2:0] strap = 0;
  logic [6:0] nv_addr = 0;
  logic [7:0] addr_byte = 0;
  logic addr_vld = 0;
  logic [6:0] eff_addr;
  logic addr_hit, rw_dir;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  i2c_addr_select #(.PREFIX(4'b1101)) uut (
    .clk(clk), .rst(rst), .strap(strap), .nv_addr(nv_addr),
    .addr_byte(addr_byte), .addr_vld(addr_vld),
    .eff_addr(eff_addr), .addr_hit(addr_hit), .rw_dir(rw_dir));

  // strap, nv_addr, byte, exp eff, exp hit, exp rw
  localparam logic [26:0] VEC [6] = '{
    {3'b101, 7'h22, 8'hDB, 7'h6D, 1'b1, 1'b1},
    {3'b000, 7'h22, 8'h44, 7'h22, 1'b1, 1'b0},
    {3'b001, 7'h50, 8'hA1, 7'h69, 1'b0, 1'b1},
    {3'b111, 7'h00, 8'hDE, 7'h6F, 1'b1, 1'b0},
    {3'b000, 7'h5A, 8'hB7, 7'h5A, 1'b0, 1'b1},
    {3'b100, 7'h00, 8'hD9, 7'h6C, 1'b1, 1'b1}};

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(logic [2:0] s, logic [6:0] nv);
    strap = s; nv_addr = nv; rst = 1;
    cyc(5);
    rst = 0;
    cyc(2);
  endtask

  task automatic strobe(logic [7:0] b);
    addr_byte = b; addr_vld = 1;
    cyc(1);
    addr_vld = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R7 reset state
    strap = 3'b011; nv_addr = 7'h33;
    cyc(4);
    chk("R7 eff", eff_addr, 0);
    chk("R7 hit", addr_hit, 0);
    chk("R7 rw", rw_dir, 0);

    for (int i = 0; i < 6; i++) begin
      logic [26:0] v;
      v = VEC[i];
      do_reset(v[26:24], v[23:17]);
      chk(v[26:24] == 0 ? "R2 eff" : "R1 eff", eff_addr, v[8:2]);
      strobe(v[16:9]);
      chk("R4 hit", addr_hit, v[1]);
      chk("R6 rw", rw_dir, v[0]);
    end

    // R3 straps frozen after release
    do_reset(3'b010, 7'h11);
    chk("R1 eff", eff_addr, 7'h6A);
    strap = 3'b000;
    cyc(6);
    chk("R3 eff", eff_addr, 7'h6A);
    strap = 3'b111;
    cyc(6);
    chk("R3 eff", eff_addr, 7'h6A);

    // R2 tracking of stored address with fallback
    do_reset(3'b000, 7'h12);
    chk("R2 eff", eff_addr, 7'h12);
    nv_addr = 7'h7E;
    cyc(1);
    chk("R2 eff", eff_addr, 7'h7E);

    // R4 bit order: reversed address must miss, true order hits
    strobe(8'h7F);
    chk("R4 hit", addr_hit, 0);
    strobe(8'hFC);
    chk("R4 hit", addr_hit, 1);
    chk("R6 rw", rw_dir, 0);

    // R5 hold between strobes
    addr_byte = 8'h01;
    cyc(3);
    chk("R5 hit", addr_hit, 1);
    chk("R5 rw", rw_dir, 0);
    strobe(8'h01);
    chk("R5 hit", addr_hit, 0);
    chk("R6 rw", rw_dir, 1);

    // R7 reset clears match
    strobe(8'hFD);
    chk("R4 hit", addr_hit, 1);
    rst = 1;
    cyc(1);
    chk("R7 hit", addr_hit, 0);
    chk("R7 rw", rw_dir, 0);
    rst = 0;
    cyc(2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule